// File: doc/BRIEF.md
# Ordered Conflict-Resolving Splitter

This block joins a group of vertex processors to a set of intermediate output buffers. Each processor offers, at the head of its own input FIFO, one record per step. A record holds a contribution value, a target buffer number and a no-op flag. The block serves a step only when every processor has a record at its head. This lockstep barrier keeps the order of buffer writes the same however memory latency varies. Each real record's contribution is then steered to its target buffer, and the buffer number itself is not passed on.

Every buffer has a single write port and takes at most one write per cycle. Records that aim at different buffers are written in the same cycle. Records that collide on one buffer are written over successive cycles, the lowest processor number first. While a step is partly served, the FIFO heads are held. When the last record of the step is written, every FIFO is popped in the same cycle. A processor with nothing to emit presents a no-op token, so zero-degree vertices never stall the barrier.

A two-state machine controls the block. In `ST_WAIT` no record of the current step has been written yet. It goes to `ST_DRAIN` when a step cannot finish in its first cycle because of a conflict. `ST_DRAIN` holds the set of records already written. It returns to `ST_WAIT` in the cycle that writes the step's last record.

Top module: `ordered_splitter`

## Requirements
- R1: After reset the block is in the waiting state with no record of any step marked as written. While no input is presented it raises no write and no pop.
- R2: Unless every processor's `in_valid` is high, no buffer write and no pop occurs in that cycle.
- R3: `in_pop` is either all zeros or all ones. It is all ones only in the cycle that writes the last outstanding record of the step, or in the first cycle of a step that has nothing to write.
- R4: Records of one step that target different buffers are all written in the same cycle, so a step without conflicts retires in one cycle.
- R5: When several records of a step target the same buffer, one record per cycle is written to it, in increasing processor number. A step takes as many cycles as the largest number of records aimed at one buffer.
- R6: Processor p supplies its buffer number in binary at `in_idx[p*IDX_W +: IDX_W]` (with IDX_W = clog2(N_BUF)) and its contribution at `in_data[p*DATA_W +: DATA_W]`. A write of that record raises `buf_wr[b]` for b equal to that number and places the contribution, unchanged, on `buf_data[b*DATA_W +: DATA_W]`. The buffer number is not forwarded.
- R7: A record with `in_noop` high counts as present for the barrier but causes no write. A step made only of no-op records pops all FIFOs in its first cycle.
- R8: In every cycle of a started step in which all inputs are valid, at least one buffer write occurs until the step retires.
- R9: While a step is partly served, no FIFO is popped, and records already written are not written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | N_PROC | FIFO head present, one bit per processor |
| in_noop | input | N_PROC | Head record is a no-op token |
| in_idx | input | N_PROC*clog2(N_BUF) | Target buffer number per processor |
| in_data | input | N_PROC*DATA_W | Contribution value per processor |
| in_pop | output | N_PROC | Pop strobe for each input FIFO (all raised together) |
| buf_wr | output | N_BUF | Write enable per output buffer |
| buf_data | output | N_BUF*DATA_W | Write data per output buffer |

## Verification
All writes and pops are decided by logic with no register between the FIFO heads and the outputs. They are therefore due in the same cycle that the heads are presented, and the only stored state is the written-records mask. The bench drives heads just after a rising edge and compares every output at the following falling edge against a behavioural model. That model advances its own mask and the FIFO queues at the rising edge. Whole steps are also timed. A conflict-free step must take one cycle, a four-way collision four cycles, and a stalled processor must add exactly its stall length.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    typedef enum logic {
        ST_WAIT  = 1'b0,
        ST_DRAIN = 1'b1
    } step_state_t;

endpackage

// File: rtl/buf_lane_arbiter.sv
module buf_lane_arbiter #(
    parameter int N_PROC = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32,
    parameter int LANE   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PROC-1:0]        pend,
    input  logic [N_PROC*IDX_W-1:0]  idx_flat,
    input  logic [N_PROC*DATA_W-1:0] data_flat,
    output logic [N_PROC-1:0]        gnt,
    output logic                     wr_en,
    output logic [DATA_W-1:0]        wr_data
);

    logic [N_PROC-1:0] req;

    always_comb begin
        for (int p = 0; p < N_PROC; p++) begin
            req[p] = pend[p] && (idx_flat[p*IDX_W +: IDX_W] == IDX_W'(LANE));
        end
    end

    // lowest processor number wins the lane
    always_comb begin
        gnt = '0;
        for (int p = N_PROC-1; p >= 0; p--) begin
            if (req[p]) begin
                gnt    = '0;
                gnt[p] = 1'b1;
            end
        end
    end

    always_comb begin
        wr_data = '0;
        for (int p = 0; p < N_PROC; p++) begin
            if (gnt[p]) begin
                wr_data = wr_data | data_flat[p*DATA_W +: DATA_W];
            end
        end
    end

    assign wr_en = |gnt;

    // R5: at most one writer per lane per cycle
    a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R5: any requester on this lane gets a write this cycle
    a_r5_lane_served: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> wr_en);

endmodule

// File: rtl/ordered_splitter.sv
module ordered_splitter
    import splitter_pkg::*;
#(
    parameter int N_PROC = 8,
    parameter int N_BUF  = 8,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_PROC-1:0]                in_valid,
    input  logic [N_PROC-1:0]                in_noop,
    input  logic [N_PROC*$clog2(N_BUF)-1:0]  in_idx,
    input  logic [N_PROC*DATA_W-1:0]         in_data,
    output logic [N_PROC-1:0]                in_pop,
    output logic [N_BUF-1:0]                 buf_wr,
    output logic [N_BUF*DATA_W-1:0]          buf_data
);

    localparam int IDX_W = $clog2(N_BUF);

    step_state_t              state_q, state_d;
    logic [N_PROC-1:0]        done_q, done_d;
    logic [N_PROC-1:0]        pend, granted;
    logic [N_BUF-1:0][N_PROC-1:0] lane_gnt;
    logic                     all_valid, step_done;

    assign all_valid = &in_valid;
    assign pend      = all_valid ? (~in_noop & ~done_q) : '0;

    generate
        for (genvar b = 0; b < N_BUF; b++) begin : g_lane
            buf_lane_arbiter #(
                .N_PROC (N_PROC),
                .IDX_W  (IDX_W),
                .DATA_W (DATA_W),
                .LANE   (b)
            ) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .pend      (pend),
                .idx_flat  (in_idx),
                .data_flat (in_data),
                .gnt       (lane_gnt[b]),
                .wr_en     (buf_wr[b]),
                .wr_data   (buf_data[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

    always_comb begin
        granted = '0;
        for (int b = 0; b < N_BUF; b++) begin
            granted = granted | lane_gnt[b];
        end
    end

    assign step_done = all_valid && ((pend & ~granted) == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            done_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        done_d  = done_q;
        unique case (state_q)
            ST_WAIT: begin
                if (all_valid && !step_done) begin
                    state_d = ST_DRAIN;
                    done_d  = granted;
                end
            end
            ST_DRAIN: begin
                if (step_done) begin
                    state_d = ST_WAIT;
                    done_d  = '0;
                end else begin
                    done_d  = done_q | granted;
                end
            end
            default: begin
                state_d = ST_WAIT;
                done_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_pop = '0;
        unique case (state_q)
            ST_WAIT:  if (step_done) in_pop = '1;
            ST_DRAIN: if (step_done) in_pop = '1;
            default:  in_pop = '0;
        endcase
    end

    a_r2_barrier: assert property (@(posedge clk) disable iff (!rst_n)
        !all_valid |-> (buf_wr == '0 && in_pop == '0));

    a_r3_pop_together: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop == '0) || (&in_pop));

    a_r7_noop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (all_valid && (&in_noop)) |-> ((&in_pop) && buf_wr == '0));

    a_r8_drain_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && all_valid) |-> (|buf_wr));

    a_r9_no_pop_midstep: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_pop) |=> (state_q == ST_WAIT));

endmodule

// File: tb/test_ordered_splitter.sv
module test_ordered_splitter;

    localparam int NP = 4;
    localparam int NB = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NP-1:0]   in_valid, in_noop, in_pop;
    logic [NP*IW-1:0] in_idx;
    logic [NP*DW-1:0] in_data;
    logic [NB-1:0]   buf_wr;
    logic [NB*DW-1:0] buf_data;

    always #10 clk = ~clk;

    ordered_splitter #(.N_PROC(NP), .N_BUF(NB), .DATA_W(DW)) i_ordered_splitter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_noop(in_noop),
        .in_idx(in_idx), .in_data(in_data), .in_pop(in_pop),
        .buf_wr(buf_wr), .buf_data(buf_data)
    );

    // record: {noop, idx[1:0], data[7:0]}
    logic [10:0] fq [NP][$];
    int          hold_until [NP];
    logic [NP-1:0] mdone;
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;

    task automatic push(input int p, input bit noop, input int idx, input int data);
        fq[p].push_back({noop, 2'(idx), 8'(data)});
    endtask

    task automatic drive();
        for (int p = 0; p < NP; p++) begin
            if (fq[p].size() > 0 && cyc >= hold_until[p]) begin
                in_valid[p]           = 1'b1;
                in_noop[p]            = fq[p][0][10];
                in_idx[p*IW +: IW]    = fq[p][0][9:8];
                in_data[p*DW +: DW]   = fq[p][0][7:0];
            end else begin
                in_valid[p]           = 1'b0;
                in_noop[p]            = 1'b0;
                in_idx[p*IW +: IW]    = '0;
                in_data[p*DW +: DW]   = '0;
            end
        end
    endtask

    function automatic bool_any_left();
        for (int p = 0; p < NP; p++) if (fq[p].size() > 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input bit ok, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // one cycle: compare at negedge against model, advance at posedge
    task automatic step_cycle(input string tag);
        logic [NB-1:0]    ew;
        logic [NB*DW-1:0] ed, ad;
        logic [NP-1:0]    eg, ep;
        bit               allv, rem;
        @(negedge clk);
        allv = 1'b1;
        for (int p = 0; p < NP; p++) if (!(fq[p].size() > 0 && cyc >= hold_until[p])) allv = 1'b0;
        ew = '0; ed = '0; eg = '0;
        if (allv) begin
            for (int b = 0; b < NB; b++) begin
                for (int p = 0; p < NP; p++) begin
                    if (!ew[b] && !mdone[p] && !fq[p][0][10] && int'(fq[p][0][9:8]) == b) begin
                        ew[b] = 1'b1;
                        ed[b*DW +: DW] = fq[p][0][7:0];
                        eg[p] = 1'b1;
                    end
                end
            end
        end
        rem = 1'b0;
        if (allv) for (int p = 0; p < NP; p++)
            if (!mdone[p] && !fq[p][0][10] && !eg[p]) rem = 1'b1;
        ep = (allv && !rem) ? '1 : '0;
        ad = '0;
        for (int b = 0; b < NB; b++) if (buf_wr[b]) ad[b*DW +: DW] = buf_data[b*DW +: DW];
        check(tag, buf_wr === ew,
              $sformatf("R6 cyc %0d buf_wr act=%b exp=%b", cyc, buf_wr, ew));
        check(tag, ad === ed,
              $sformatf("R5 cyc %0d buf_data act=%h exp=%h", cyc, ad, ed));
        check(tag, in_pop === ep,
              $sformatf("R3 cyc %0d in_pop act=%b exp=%b", cyc, in_pop, ep));
        @(posedge clk);
        #1;
        if (ep != '0) begin
            for (int p = 0; p < NP; p++) void'(fq[p].pop_front());
            mdone = '0;
        end else begin
            mdone = mdone | eg;
        end
        cyc++;
        drive();
    endtask

    task automatic run_phase(input string tag, output int cycles);
        cycles = 0;
        drive();
        while (bool_any_left() && cycles < 2000) begin
            step_cycle(tag);
            cycles++;
        end
        check(tag, !bool_any_left(), $sformatf("R8 queues not drained act=1 exp=0"));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog expired act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cycles;
        int unsigned seed;
        rst_n = 1'b0;
        mdone = '0;
        for (int p = 0; p < NP; p++) hold_until[p] = 0;
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", buf_wr == '0 && in_pop == '0,
              $sformatf("R1 in reset wr=%b pop=%b exp 0", buf_wr, in_pop));
        rst_n = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        check("R1", buf_wr == '0 && in_pop == '0,
              $sformatf("R1 after reset wr=%b pop=%b exp 0", buf_wr, in_pop));
        @(posedge clk); #1;

        // R4 R6: distinct targets, one cycle per step
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < NP; p++) push(p, 0, (p + k) % NB, 16 * k + p + 1);
        run_phase("R4", cycles);
        check("R4", cycles == 3, $sformatf("R4 cycles act=%0d exp=3", cycles));

        // R5: four-way collision on buffer 1
        for (int p = 0; p < NP; p++) push(p, 0, 1, 8'hA0 + p);
        run_phase("R5", cycles);
        check("R5", cycles == 4, $sformatf("R5 cycles act=%0d exp=4", cycles));

        // R7: all no-op step, then mixed step with a 2-way collision
        for (int p = 0; p < NP; p++) push(p, 1, 3, 8'hEE);
        push(0, 1, 0, 0); push(1, 0, 2, 8'h51); push(2, 1, 2, 0); push(3, 0, 2, 8'h53);
        run_phase("R7", cycles);
        check("R7", cycles == 3, $sformatf("R7 cycles act=%0d exp=3", cycles));

        // R2 R9: processor 3 late by five cycles, then 3-way on buffer 0
        hold_until[3] = cyc + 5;
        push(0, 0, 0, 8'h10); push(1, 0, 0, 8'h11); push(2, 0, 3, 8'h12); push(3, 0, 0, 8'h13);
        run_phase("R2/R9", cycles);
        check("R2", cycles == 8, $sformatf("R2 cycles act=%0d exp=8", cycles));

        // R8 R6: mixed pseudo-random steps
        seed = 32'h1234_5678;
        for (int k = 0; k < 30; k++) begin
            for (int p = 0; p < NP; p++) begin
                seed = seed * 1103515245 + 12345;
                push(p, seed[28:26] == 3'd0, int'(seed[17:16]), int'(seed[11:4]));
            end
        end
        run_phase("R8", cycles);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule